// File: doc/BRIEF.md
# Bus Activity Monitor Channel

This block watches one stream of bus traffic and measures how busy it is. Each pulse on the event input adds a programmable weight to a raw counter. A sampling period is a programmable number of pulses on the period tick input. When a period closes, the raw count is folded into a shift-based exponential moving average, and the raw counter restarts from zero.

At every period boundary the block makes two kinds of check. The new average is compared against an upper and a lower band limit. The raw count is compared against its own upper and lower watermarks. Two run counters record how many periods in a row the raw count has stayed beyond each watermark. When a run reaches its programmed length, the block raises a status bit and the run starts again. Software reads and writes the block through a simple word-addressed register port. Any set status bit drives the interrupt output, and status bits are cleared by writing ones to them.

Top module: `busact_chan`

## Requirements
- R1: Registers are reached by word index: 0 control, 1 raw upper watermark, 2 raw lower watermark, 3 initial average, 4 average upper limit, 5 average lower limit, 6 count weight, 7 average (read only), 8 status, 9 period length. Every writable register reads back what was written, and every register reads zero after reset.
- R2: Each cycle with the event input high, while the channel runs, adds the count weight to the raw count. At a period end the average becomes avg - (avg >> (K+1)) + (count >> (K+1)), where K is control bits 12:10, and the raw count restarts. An event that arrives in the same cycle as a period end counts toward the next period.
- R3: Control bit 31 is the channel enable and bit 18 the periodic enable. Period ticks are counted only while both bits are set. A period ends on tick number N+1, where N is the period-length register. While either bit is clear, ticks leave the average unchanged.
- R4: A period whose raw count is strictly greater than the raw upper watermark extends the above-run, and any other period resets the run to zero. When the run reaches (control bits 28:26) + 1 periods, it restarts from zero, and status bit 31 is set if control bit 30 is set.
- R5: A period whose raw count is strictly less than the raw lower watermark extends the below-run, and any other period resets it. When the run reaches (control bits 25:23) + 1 periods, it restarts from zero, and status bit 30 is set if control bit 29 is set.
- R6: At a period end, a new average strictly above the upper limit sets status bit 1 if control bit 21 is set. A new average strictly below the lower limit sets status bit 0 if control bit 20 is set.
- R7: Writing to status clears each bit that is written as one and leaves every other bit unchanged. Writing zero has no effect. If a bit is set and cleared in the same cycle, the set wins.
- R8: The interrupt output is high exactly when at least one status bit is set.
- R9: While the channel enable is clear, the average follows the initial-average register, and the raw count and both runs are held at zero. This is how the average is seeded before the channel is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr, combinational |
| eventPulse | input | 1 | One weighted bus event per high cycle |
| periodTick | input | 1 | Time base for the sampling period |
| irq | output | 1 | Interrupt, high while any status bit is set |

## Verification
The hardest case to reach is a run of consecutive periods that is broken before it reaches its window length. The run counters cannot be read, so a broken run looks exactly like a run that never started. The stimulus therefore drives an above-watermark period, then an empty one, then another above period, and checks that no status bit appears. One more above period must then fire, which shows that the run restarted from zero rather than stopping. Average band crossings are reached by seeding a known value while the channel is disabled. The averages after each period are worked out by hand, so that one crossing lands after exactly one period and the other after exactly three.

// File: rtl/busact_pkg.sv
package busact_pkg;
  localparam int CTRL_EN      = 31;
  localparam int CTRL_ABV_EN  = 30;
  localparam int CTRL_BEL_EN  = 29;
  localparam int CTRL_ABV_WIN = 26;
  localparam int CTRL_BEL_WIN = 23;
  localparam int CTRL_AVGA_EN = 21;
  localparam int CTRL_AVGB_EN = 20;
  localparam int CTRL_PERIOD  = 18;
  localparam int CTRL_K       = 10;
  localparam int K_W          = 3;
  localparam int WIN_W        = 3;

  localparam int ST_ABV  = 31;
  localparam int ST_BEL  = 30;
  localparam int ST_AVGA = 1;
  localparam int ST_AVGB = 0;

  typedef enum logic [3:0] {
    A_CTRL = 4'd0, A_RAWHI = 4'd1, A_RAWLO = 4'd2, A_INIT = 4'd3,
    A_AVGHI = 4'd4, A_AVGLO = 4'd5, A_WEIGHT = 4'd6, A_AVG = 4'd7,
    A_STATUS = 4'd8, A_PERIOD = 4'd9
  } regIdx_e;

  typedef struct packed {
    logic           run;
    logic           periodEnd;
    logic [K_W-1:0] kVal;
  } dpStrobe_t;

  typedef struct packed {
    logic rawAbove;
    logic rawBelow;
    logic avgAbove;
    logic avgBelow;
  } dpFlags_t;
endpackage

// File: rtl/busact_dp.sv
module busact_dp
  import busact_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              eventPulse,
  input  logic [DATA_W-1:0] weight,
  input  logic [DATA_W-1:0] initAvg,
  input  logic [DATA_W-1:0] rawUpper,
  input  logic [DATA_W-1:0] rawLower,
  input  logic [DATA_W-1:0] avgUpper,
  input  logic [DATA_W-1:0] avgLower,
  output logic [DATA_W-1:0] avgQ,
  output logic [DATA_W-1:0] rawCountQ,
  output dpFlags_t          flags
);
  localparam int SH_W = K_W + 1;

  logic [SH_W-1:0]   shAmt;
  logic [DATA_W-1:0] avgNext;

  assign shAmt   = {1'b0, strobe.kVal} + SH_W'(1);
  assign avgNext = avgQ - (avgQ >> shAmt) + (rawCountQ >> shAmt);

  always_comb begin
    flags.rawAbove = rawCountQ > rawUpper;
    flags.rawBelow = rawCountQ < rawLower;
    flags.avgAbove = avgNext > avgUpper;
    flags.avgBelow = avgNext < avgLower;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawCountQ <= '0;
      avgQ      <= '0;
    end else if (!strobe.run) begin
      rawCountQ <= '0;
      avgQ      <= initAvg;
    end else if (strobe.periodEnd) begin
      rawCountQ <= eventPulse ? weight : '0;
      avgQ      <= avgNext;
    end else if (eventPulse) begin
      rawCountQ <= rawCountQ + weight;
    end
  end
endmodule

// File: rtl/busact_ctrl.sv
module busact_ctrl
  import busact_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PER_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [3:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              periodTick,
  input  logic [DATA_W-1:0] avgQ,
  input  dpFlags_t          flags,
  output dpStrobe_t         strobe,
  output logic [DATA_W-1:0] ctrlQ,
  output logic [DATA_W-1:0] statusQ,
  output logic [DATA_W-1:0] weightQ,
  output logic [DATA_W-1:0] initAvgQ,
  output logic [DATA_W-1:0] rawHiQ,
  output logic [DATA_W-1:0] rawLoQ,
  output logic [DATA_W-1:0] avgHiQ,
  output logic [DATA_W-1:0] avgLoQ
);
  localparam int RUN_W = WIN_W + 1;
  localparam int NDIR  = 2;

  logic [PER_W-1:0]  periodQ, tickCnt;
  logic              tickEn, periodEnd;
  logic [DATA_W-1:0] setBits, clrMask;
  logic [NDIR-1:0]   fire;

  assign tickEn    = ctrlQ[CTRL_EN] & ctrlQ[CTRL_PERIOD];
  assign periodEnd = tickEn & periodTick & (tickCnt == periodQ);

  assign strobe.run       = ctrlQ[CTRL_EN];
  assign strobe.periodEnd = periodEnd;
  assign strobe.kVal      = ctrlQ[CTRL_K +: K_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   tickCnt <= '0;
    else if (!tickEn)            tickCnt <= '0;
    else if (periodEnd)          tickCnt <= '0;
    else if (periodTick)         tickCnt <= tickCnt + PER_W'(1);
  end

  // consecutive-period runs: index 0 above, index 1 below
  for (genvar d = 0; d < NDIR; d++) begin : g_run
    logic [RUN_W-1:0] runCnt, runNext, winLen;
    logic             hit;
    assign hit     = (d == 0) ? flags.rawAbove : flags.rawBelow;
    assign winLen  = {1'b0, ctrlQ[((d == 0) ? CTRL_ABV_WIN : CTRL_BEL_WIN) +: WIN_W]} + RUN_W'(1);
    assign runNext = hit ? runCnt + RUN_W'(1) : '0;
    assign fire[d] = hit && (runNext == winLen);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 runCnt <= '0;
      else if (!ctrlQ[CTRL_EN])  runCnt <= '0;
      else if (periodEnd)        runCnt <= fire[d] ? '0 : runNext;
    end
  end

  always_comb begin
    setBits          = '0;
    setBits[ST_ABV]  = periodEnd & fire[0] & ctrlQ[CTRL_ABV_EN];
    setBits[ST_BEL]  = periodEnd & fire[1] & ctrlQ[CTRL_BEL_EN];
    setBits[ST_AVGA] = periodEnd & flags.avgAbove & ctrlQ[CTRL_AVGA_EN];
    setBits[ST_AVGB] = periodEnd & flags.avgBelow & ctrlQ[CTRL_AVGB_EN];
    clrMask          = (regWr && regAddr == A_STATUS) ? regWdata : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0; rawHiQ <= '0; rawLoQ <= '0; initAvgQ <= '0;
      avgHiQ <= '0; avgLoQ <= '0; weightQ <= '0; periodQ <= '0;
      statusQ <= '0;
    end else begin
      statusQ <= (statusQ & ~clrMask) | setBits;
      if (regWr) begin
        case (regAddr)
          A_CTRL:   ctrlQ    <= regWdata;
          A_RAWHI:  rawHiQ   <= regWdata;
          A_RAWLO:  rawLoQ   <= regWdata;
          A_INIT:   initAvgQ <= regWdata;
          A_AVGHI:  avgHiQ   <= regWdata;
          A_AVGLO:  avgLoQ   <= regWdata;
          A_WEIGHT: weightQ  <= regWdata;
          A_PERIOD: periodQ  <= regWdata[PER_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (regAddr)
      A_CTRL:   regRdata = ctrlQ;
      A_RAWHI:  regRdata = rawHiQ;
      A_RAWLO:  regRdata = rawLoQ;
      A_INIT:   regRdata = initAvgQ;
      A_AVGHI:  regRdata = avgHiQ;
      A_AVGLO:  regRdata = avgLoQ;
      A_WEIGHT: regRdata = weightQ;
      A_AVG:    regRdata = avgQ;
      A_STATUS: regRdata = statusQ;
      A_PERIOD: regRdata = DATA_W'(periodQ);
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: rtl/busact_chan.sv
module busact_chan
  import busact_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PER_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [3:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              eventPulse,
  input  logic              periodTick,
  output logic              irq
);
  dpStrobe_t         strobe;
  dpFlags_t          flags;
  logic [DATA_W-1:0] avgQ, rawCountQ, ctrlQ, statusQ, weightQ, initAvgQ;
  logic [DATA_W-1:0] rawHiQ, rawLoQ, avgHiQ, avgLoQ;

  busact_ctrl #(.DATA_W(DATA_W), .PER_W(PER_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .periodTick(periodTick),
    .avgQ(avgQ), .flags(flags), .strobe(strobe), .ctrlQ(ctrlQ),
    .statusQ(statusQ), .weightQ(weightQ), .initAvgQ(initAvgQ),
    .rawHiQ(rawHiQ), .rawLoQ(rawLoQ), .avgHiQ(avgHiQ), .avgLoQ(avgLoQ)
  );

  busact_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .eventPulse(eventPulse),
    .weight(weightQ), .initAvg(initAvgQ), .rawUpper(rawHiQ),
    .rawLower(rawLoQ), .avgUpper(avgHiQ), .avgLower(avgLoQ),
    .avgQ(avgQ), .rawCountQ(rawCountQ), .flags(flags)
  );

  assign irq = |statusQ;
endmodule

// File: rtl/busact_chk.sv
module busact_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] ctrl,
  input logic [DATA_W-1:0] status,
  input logic [DATA_W-1:0] avg,
  input logic [DATA_W-1:0] initAvg,
  input logic [DATA_W-1:0] rawCount,
  input logic              periodEnd
);
  a_r9_idle_count_zero: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl[31] |=> rawCount == '0);

  a_r9_idle_avg_seeded: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl[31] |=> avg == $past(initAvg));

  a_r2_avg_moves_at_period_end: assert property (@(posedge clk) disable iff (!rstN)
    ctrl[31] && !periodEnd |=> $stable(avg));

  a_r4_above_gated: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl[30] && !status[31] |=> !status[31]);

  a_r5_below_gated: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl[29] && !status[30] |=> !status[30]);

  a_r6_avg_bits_need_period: assert property (@(posedge clk) disable iff (!rstN)
    !periodEnd && status[1:0] == 2'b00 |=> status[1:0] == 2'b00);
endmodule

bind busact_chan busact_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .ctrl(ctrlQ), .status(statusQ), .avg(avgQ),
  .initAvg(initAvgQ), .rawCount(rawCountQ), .periodEnd(strobe.periodEnd)
);

// File: tb/sim_busact_chan.sv
module sim_busact_chan;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        eventPulse = 1'b0;
  logic        periodTick = 1'b0;
  logic        irq;
  int          nChecks = 0;
  int          nFails = 0;

  always #4 clk = ~clk;

  busact_chan u0 (.clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .eventPulse(eventPulse),
    .periodTick(periodTick), .irq(irq));

  function automatic logic [31:0] mkCtrl(input bit en, input bit per, input int k,
      input int belWin, input int abvWin, input bit enBel, input bit enAbv,
      input bit enAvgB, input bit enAvgA);
    logic [31:0] v = '0;
    v[31] = en; v[18] = per; v[12:10] = 3'(k);
    v[25:23] = 3'(belWin - 1); v[28:26] = 3'(abvWin - 1);
    v[29] = enBel; v[30] = enAbv; v[20] = enAvgB; v[21] = enAvgA;
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdata;
  endtask

  task automatic events(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); eventPulse = 1'b1;
      @(negedge clk); eventPulse = 1'b0;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); periodTick = 1'b1;
      @(negedge clk); periodTick = 1'b0;
    end
  endtask

  task automatic testReset();
    logic [31:0] v;
    rd(4'd0, v); check("R1 ctrl after reset", v, 0);
    rd(4'd8, v); check("R1 status after reset", v, 0);
    rd(4'd7, v); check("R1 avg after reset", v, 0);
    check("R8 irq after reset", {31'd0, irq}, 0);
  endtask

  task automatic testRegs();
    logic [31:0] v;
    wr(4'd1, 32'h0000_1234); rd(4'd1, v); check("R1 raw upper readback", v, 32'h1234);
    wr(4'd5, 32'h00AB_CDEF); rd(4'd5, v); check("R1 avg lower readback", v, 32'h00AB_CDEF);
    wr(4'd9, 32'd11);        rd(4'd9, v); check("R1 period readback", v, 11);
    wr(4'd1, 0); wr(4'd5, 0);
  endtask

  task automatic testSeedAndAverage();
    logic [31:0] v;
    wr(4'd3, 100); wr(4'd6, 5); wr(4'd9, 0);
    rd(4'd7, v); check("R9 avg follows seed while disabled", v, 100);
    wr(4'd0, mkCtrl(1, 1, 0, 1, 1, 0, 0, 0, 0));
    events(4); ticks(1);
    rd(4'd7, v); check("R2 avg with K=0", v, 60);
    wr(4'd0, mkCtrl(1, 1, 2, 1, 1, 0, 0, 0, 0));
    events(8); ticks(1);
    rd(4'd7, v); check("R2 avg with K=2", v, 58);
  endtask

  task automatic testPeriodLength();
    logic [31:0] v;
    wr(4'd0, 0); wr(4'd9, 2);
    wr(4'd0, mkCtrl(1, 1, 0, 1, 1, 0, 0, 0, 0));
    events(2); ticks(2);
    rd(4'd7, v); check("R3 no period end before N+1 ticks", v, 100);
    ticks(1);
    rd(4'd7, v); check("R3 period end on tick N+1", v, 55);
    wr(4'd0, mkCtrl(1, 0, 0, 1, 1, 0, 0, 0, 0));
    ticks(4);
    rd(4'd7, v); check("R3 ticks ignored without periodic enable", v, 55);
  endtask

  task automatic testAbove();
    logic [31:0] v;
    wr(4'd0, 0); wr(4'd9, 0); wr(4'd1, 10); wr(4'd2, 0);
    wr(4'd0, mkCtrl(1, 1, 0, 1, 2, 0, 1, 0, 0));
    events(4); ticks(1);
    rd(4'd8, v); check("R4 one above period is not enough", v, 0);
    events(4); ticks(1);
    rd(4'd8, v); check("R4 above run of two fires", v, 32'h8000_0000);
    check("R8 irq follows status", {31'd0, irq}, 1);
    wr(4'd8, 32'h8000_0000);
    rd(4'd8, v); check("R7 write-one clears", v, 0);
    check("R8 irq low after clear", {31'd0, irq}, 0);
    events(4); ticks(1); ticks(1); events(4); ticks(1);
    rd(4'd8, v); check("R4 broken run does not fire", v, 0);
    events(4); ticks(1);
    rd(4'd8, v); check("R4 run restarted after break", v, 32'h8000_0000);
    wr(4'd8, 32'hFFFF_FFFF);
    wr(4'd0, mkCtrl(1, 1, 0, 1, 2, 0, 0, 0, 0));
    events(4); ticks(1); events(4); ticks(1);
    rd(4'd8, v); check("R4 no status with interrupt disabled", v, 0);
  endtask

  task automatic testBelow();
    logic [31:0] v;
    wr(4'd0, 0); wr(4'd1, 32'hFFFF_FFFF); wr(4'd2, 10);
    wr(4'd0, mkCtrl(1, 1, 0, 3, 1, 1, 0, 0, 0));
    ticks(2);
    rd(4'd8, v); check("R5 two below periods not enough", v, 0);
    ticks(1);
    rd(4'd8, v); check("R5 below run of three fires", v, 32'h4000_0000);
    wr(4'd8, 0);
    rd(4'd8, v); check("R7 writing zero has no effect", v, 32'h4000_0000);
    wr(4'd8, 32'h4000_0000);
  endtask

  task automatic testAvgBand();
    logic [31:0] v;
    wr(4'd0, 0); wr(4'd3, 100); wr(4'd6, 100); wr(4'd4, 200); wr(4'd5, 50);
    wr(4'd0, mkCtrl(1, 1, 0, 1, 1, 0, 0, 1, 1));
    events(4); ticks(1);
    rd(4'd8, v); check("R6 average above upper limit", v, 32'h2);
    wr(4'd8, 32'h2);
    ticks(1);
    rd(4'd8, v); check("R6 average inside band", v, 0);
    ticks(2);
    rd(4'd8, v); check("R6 average below lower limit", v, 32'h1);
    rd(4'd7, v); check("R2 average decay", v, 32);
  endtask

  initial begin
    #(8 * 150000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegs();
    testSeedAndAverage();
    testPeriodLength();
    testAbove();
    testBelow();
    testAvgBand();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule